// File: doc/BRIEF.md
# Stoppable Four-Phase Clock Generator

This block turns a single master clock into four phase-enable outputs that take turns in a fixed rotating order, one phase per enabled master clock cycle. Exactly one phase output is high in each enabled cycle. The outputs never overlap.

A run input tells the generator whether the master clock counts as running. When run is low, as during a scan test, the generator keeps its position and drives every phase output low. When run returns high, it continues with the phase that follows the last one it emitted, so no phase is ever skipped.

A sync input arms the generator so that the next enabled edge emits the first phase, whatever position was held. Several copies on different chips can therefore be given sync while the clock is stopped, and all of them start together on the restart edge. A synchronous reset leaves the generator armed. A 2-bit debug output reports the index of the current phase.

Top module: `quad_phase_gen`

## Requirements
- R1: A clock edge with rst_n low clears phase_en to 0 and phase_idx to 0 and leaves the generator armed, so the first edge with run high afterwards produces phase_en = 4'b0001.
- R2: On successive edges with run high and sync_arm low, phase_en rotates 4'b0001 → 4'b0010 → 4'b0100 → 4'b1000 → 4'b0001, with bit 0 the first phase. After any enabled edge exactly one bit is set.
- R3: After an edge with run low, phase_en is 4'b0000 and phase_idx is unchanged.
- R4: After one or more stopped edges with no sync_arm, the next edge with run high produces the phase that follows the last phase emitted before the stop.
- R5: sync_arm high on an edge with run low arms the generator. The next edge with run high produces phase_en = 4'b0001, whatever position was held, and the output stays low until that edge.
- R6: sync_arm high on an edge with run high makes that same edge produce phase_en = 4'b0001, which overrides the normal advance.
- R7: phase_idx gives the zero-based number of the last emitted phase: 0 for bit 0 up to 3 for bit 3. Whenever phase_en is non-zero, phase_en[phase_idx] is 1.
- R8: Two copies that have drifted apart and are both given sync_arm while stopped emit identical phase_en and phase_idx from the common restart edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High when the master clock counts as running |
| sync_arm | input | 1 | Arms a restart at the first phase |
| phase_en | output | 4 | One-hot phase enables, bit 0 is the first phase |
| phase_idx | output | 2 | Debug index of the current phase |

## Verification
Every result appears one cycle after the rising edge that samples run and sync_arm: phase_en, phase_idx and the arming all update on that edge and show at the outputs in the following cycle. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge, and the bench compares the outputs on the next falling edge, so each check looks at exactly the edge that its stimulus reached. The stop, resume, sync-while-stopped and sync-while-running cases each have their own stretch of stimulus. A second instance that has been pushed out of step checks the restart alignment.

// File: rtl/qpg_pkg.sv
// Shared types for the four-phase generator.
// Assumes: nothing beyond standard SystemVerilog.
package qpg_pkg;
    // What the sequencer does on the current edge
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,   // clock treated as stopped
        ACT_START = 2'd1,   // jump to the first phase
        ACT_NEXT  = 2'd2    // advance one phase
    } step_act_e;
endpackage

// File: rtl/qpg_seq_ctrl.sv
// Sequencer for the phase generator: keeps the phase index and the armed flag.
// Assumes: run and sync_arm are synchronous to clk. Reset is synchronous and active low.
module qpg_seq_ctrl
    import qpg_pkg::*;
#(
    parameter int NUM_PHASES = 4,
    parameter int IDX_W      = $clog2(NUM_PHASES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync_arm,
    output step_act_e        act,
    output logic [IDX_W-1:0] idx_d,
    output logic [IDX_W-1:0] idx_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PHASES - 1);

    logic armed_q;
    logic armed_d;

    // Choose the action for this edge: a stop first, then arming or sync, then advance
    always_comb begin
        if (!run)
            act = ACT_HOLD;
        else if (armed_q || sync_arm)
            act = ACT_START;
        else
            act = ACT_NEXT;
    end

    // Next index and armed state for the chosen action
    always_comb begin
        idx_d   = idx_q;
        armed_d = armed_q;
        unique case (act)
            ACT_HOLD:  armed_d = armed_q | sync_arm;
            ACT_START: begin
                idx_d   = '0;
                armed_d = 1'b0;
            end
            ACT_NEXT: begin
                idx_d   = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
                armed_d = 1'b0;
            end
            default:   armed_d = armed_q;
        endcase
    end

    // State registers; reset leaves the generator armed at index 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            armed_q <= 1'b1;
        end else begin
            idx_q   <= idx_d;
            armed_q <= armed_d;
        end
    end
endmodule

// File: rtl/qpg_phase_out.sv
// Output stage: registers one enable per phase, decoded from the next index.
// Assumes: fire is high only on edges where the clock counts as running.
module qpg_phase_out #(
    parameter int NUM_PHASES = 4,
    parameter int IDX_W      = $clog2(NUM_PHASES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic [IDX_W-1:0]      idx_d,
    output logic [NUM_PHASES-1:0] phase_q
);
    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
        // One enable flop; high only when this phase is selected on a running edge
        always_ff @(posedge clk) begin
            if (!rst_n)
                phase_q[i] <= 1'b0;
            else
                phase_q[i] <= fire && (idx_d == IDX_W'(i));
        end
    end
endmodule

// File: rtl/quad_phase_gen.sv
// Top of the stoppable phase generator: sequencer plus registered one-hot outputs.
// Assumes: all inputs are synchronous to clk. Every output is registered.
module quad_phase_gen
    import qpg_pkg::*;
#(
    parameter int NUM_PHASES = 4,
    parameter int IDX_W      = $clog2(NUM_PHASES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  sync_arm,
    output logic [NUM_PHASES-1:0] phase_en,
    output logic [IDX_W-1:0]      phase_idx
);
    step_act_e        act;
    logic [IDX_W-1:0] idx_d;
    logic [IDX_W-1:0] idx_q;

    qpg_seq_ctrl #(.NUM_PHASES(NUM_PHASES), .IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sync_arm (sync_arm),
        .act      (act),
        .idx_d    (idx_d),
        .idx_q    (idx_q)
    );

    qpg_phase_out #(.NUM_PHASES(NUM_PHASES), .IDX_W(IDX_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (act != ACT_HOLD),
        .idx_d   (idx_d),
        .phase_q (phase_en)
    );

    assign phase_idx = idx_q;
endmodule

// File: rtl/qpg_checker.sv
// Property checker for quad_phase_gen, attached with bind.
// Assumes: the same clock and synchronous active-low reset as the design.
module qpg_checker #(
    parameter int NUM_PHASES = 4,
    parameter int IDX_W      = $clog2(NUM_PHASES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  run,
    input logic                  sync_arm,
    input logic [NUM_PHASES-1:0] phase_en,
    input logic [IDX_W-1:0]      phase_idx
);
    // R2
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_en));

    // R2
    phase_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sync_arm && (phase_en != '0))
        |=> (phase_en == {$past(phase_en[NUM_PHASES-2:0]), $past(phase_en[NUM_PHASES-1])}));

    // R3
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase_en == '0));

    // R3
    stop_hold_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(phase_idx));

    // R6
    sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sync_arm) |=> (phase_en == NUM_PHASES'(1)));

    // R7
    idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en != '0) |-> phase_en[phase_idx]);
endmodule

bind quad_phase_gen qpg_checker #(.NUM_PHASES(NUM_PHASES), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sync_arm  (sync_arm),
    .phase_en  (phase_en),
    .phase_idx (phase_idx)
);

// File: tb/sim_quad_phase_gen.sv
// Bench for quad_phase_gen: behavioural model compared on every clock.
`timescale 1ns/1ps
module sim_quad_phase_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run0 = 1'b0, run1 = 1'b0, sync_arm = 1'b0;
    logic [3:0] ph0, ph1;
    logic [1:0] ix0, ix1;
    int checks = 0, fails = 0;
    bit done = 1'b0;
    int m_idx[2], m_arm[2], m_ph[2];

    always #4 clk = ~clk;   // 125 MHz

    quad_phase_gen u0 (.clk(clk), .rst_n(rst_n), .run(run0), .sync_arm(sync_arm),
                       .phase_en(ph0), .phase_idx(ix0));
    quad_phase_gen u1 (.clk(clk), .rst_n(rst_n), .run(run1), .sync_arm(sync_arm),
                       .phase_en(ph1), .phase_idx(ix1));

    // Behavioural model of one copy for one rising edge
    task automatic model_edge(int k, logic r);
        if (!rst_n) begin
            m_idx[k] = 0; m_arm[k] = 1; m_ph[k] = 0;
        end else if (!r) begin
            if (sync_arm) m_arm[k] = 1;
            m_ph[k] = 0;
        end else begin
            if (m_arm[k] != 0 || sync_arm) m_idx[k] = 0;
            else m_idx[k] = (m_idx[k] + 1) % 4;
            m_arm[k] = 0;
            m_ph[k] = 1 << m_idx[k];
        end
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Drive inputs, take one edge, then compare away from the edge
    task automatic step(logic rs, logic r0, logic r1, logic s, string tag);
        rst_n = rs; run0 = r0; run1 = r1; sync_arm = s;
        @(posedge clk);
        model_edge(0, r0);
        model_edge(1, r1);
        @(negedge clk);
        check(tag, "u0 phase_en", int'(ph0), m_ph[0]);
        check(tag, "u0 phase_idx", int'(ix0), m_idx[0]);
        check(tag, "u1 phase_en", int'(ph1), m_ph[1]);
        check(tag, "u1 phase_idx", int'(ix1), m_idx[1]);
        if (tag == "R8") begin
            check("R8", "copies phase_en equal", int'(ph0), int'(ph1));
            check("R8", "copies phase_idx equal", int'(ix0), int'(ix1));
        end
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b0, "R1");
        check("R1", "reset phase_en zero", int'(ph0), 0);
        step(1'b1, 1'b1, 1'b1, 1'b0, "R1");
        check("R1", "first phase after reset", int'(ph0), 1);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        check("R3", "outputs low while stopped", int'(ph0), 0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R4");
        // stop on each position to check resume from every phase
        for (int j = 0; j < 4; j++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
            step(1'b1, 1'b0, 1'b0, 1'b0, "R7");
            step(1'b1, 1'b1, 1'b1, 1'b0, "R4");
        end
        step(1'b1, 1'b1, 1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R5");
        check("R5", "phase 1 after armed restart", int'(ph0), 1);
        step(1'b1, 1'b1, 1'b1, 1'b0, "R2");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R2");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R6");
        check("R6", "sync while running gives phase 1", int'(ph0), 1);
        step(1'b1, 1'b1, 1'b1, 1'b0, "R7");
        // push the copies out of step
        step(1'b1, 1'b1, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R2");
        check("R8", "copies drifted apart", int'(ph0 != ph1), 1);
        step(1'b1, 1'b0, 1'b0, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R8");
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule